// File: doc/BRIEF.md
# Signed-Amount Shift and Rotate Unit

A purely combinational unit that moves the bits of a data word left or right under a three-bit operation code and a signed shift amount. It offers three kinds of movement: logical, arithmetic and circular. Each kind comes in a leftward and a rightward form. A negative amount turns the chosen operation into its partner of the same kind going the other way, by the magnitude of the amount.

The word width is a parameter, four bits by default. The amount is a two's-complement field. It is wide enough to express plus or minus the word width. The result follows the inputs in the same cycle, with no clock and no stored state, so the unit can sit inside any pipeline stage of the surrounding datapath.

Top module: `shift_rotate_unit`

## Requirements
- R1: Code 000 shifts left and code 001 shifts right, both logically, and every vacated bit becomes 0 (1100 left by 2 gives 0000; 1100 right by 2 gives 0011; 1101 left by 3 gives 1000; 1101 right by 3 gives 0001).
- R2: Code 010 shifts left arithmetically: each vacated low bit takes the value of the input's bit 0 (1110 by 1 gives 1100; 0111 by 1 gives 1111).
- R3: Code 011 shifts right arithmetically: each vacated high bit repeats the input's most significant bit (1100 by 1 gives 1110).
- R4: Code 100 rotates left and code 101 rotates right; bits leaving one end re-enter at the other, so the number of ones is preserved (1100 by 2 gives 0011 in both directions).
- R5: A negative amount performs the opposite-direction operation of the same kind by the absolute amount (1100 arithmetic-right by -1 gives 1000; rotate-left by -1 gives 0110; rotate-right by -1 gives 1001).
- R6: Codes 110 and 111 pass the data through unchanged, whatever the amount.
- R7: An amount of zero returns the input unchanged for every code.
- R8: For a shift (codes 000 to 011) whose magnitude is at least the width, every output bit equals that operation's fill: 0 for logical, the replicated end bit for arithmetic.
- R9: For a rotate, the magnitude is taken modulo the width (a rotate by the width returns the input).
- R10: The output is a function of the present inputs only and settles within the same cycle; the result matches an independent reference for every code, data value and amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | DATA_W | Word to be shifted or rotated |
| opSel | input | 3 | Operation code (000 LSL, 001 LSR, 010 ASL, 011 ASR, 100 ROL, 101 ROR, 11x pass) |
| amount | input | AMT_W | Signed two's-complement shift amount |
| dataOut | output | DATA_W | Shifted or rotated result |

## Verification
Immediate assertions, evaluated whenever the inputs change, check several behaviours. Pass-through codes leave the word intact, a zero count is the identity, and a rotate keeps the population count. A saturated logical shift gives zero, a saturated arithmetic shift gives a uniform word, and the decoded operation kind is never ambiguous. Exact bit placement needs the bench's scenarios: the choice of fill bit, the direction swap for negative amounts and the modulo reduction of rotate counts. The bench covers these with the listed example vectors and an exhaustive sweep against a bit-by-bit reference.

// File: rtl/srot_pkg.sv
package srot_pkg;

  typedef enum logic [2:0] {
    OP_LSL  = 3'b000,
    OP_LSR  = 3'b001,
    OP_ASL  = 3'b010,
    OP_ASR  = 3'b011,
    OP_ROL  = 3'b100,
    OP_ROR  = 3'b101,
    OP_PAS0 = 3'b110,
    OP_PAS1 = 3'b111
  } srotOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic pass;       // leave the word untouched
    logic goLeft;     // effective direction after sign handling
    logic isLogical;  // zero fill
    logic isArith;    // end-bit fill
    logic isRotate;   // circular
    logic saturate;   // shift magnitude reached the width
  } srotCtrl_t;

endpackage

// File: rtl/srot_control.sv
module srot_control
  import srot_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int AMT_W  = $clog2(DATA_W) + 2,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [2:0]       opSel,
  input  logic [AMT_W-1:0] amount,
  output srotCtrl_t        ctrl,
  output logic [CNT_W-1:0] count
);

  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] WIDTH_A = AMT_W'(DATA_W);
  localparam bit   POW2    = (DATA_W == (1 << LOG_W));

  logic             isNeg;
  logic [AMT_W-1:0] magnitude;
  logic [CNT_W-1:0] rotCount;
  logic             baseLeft;

  assign isNeg     = amount[AMT_W-1];
  assign magnitude = isNeg ? (~amount + 1'b1) : amount;

  generate
    if (POW2) begin : g_rot_slice
      assign rotCount = CNT_W'(magnitude[LOG_W-1:0]);
    end else begin : g_rot_mod
      logic [AMT_W-1:0] remainder;
      assign remainder = magnitude % WIDTH_A;
      assign rotCount  = CNT_W'(remainder);
    end
  endgenerate

  always_comb begin
    baseLeft       = ~opSel[0];
    ctrl           = '0;
    ctrl.pass      = opSel[2] & opSel[1];
    ctrl.isLogical = (opSel[2:1] == 2'b00);
    ctrl.isArith   = (opSel[2:1] == 2'b01);
    ctrl.isRotate  = (opSel[2:1] == 2'b10);
    ctrl.goLeft    = baseLeft ^ isNeg;
    ctrl.saturate  = ~ctrl.isRotate & ~ctrl.pass & (magnitude >= WIDTH_A);
    if (ctrl.isRotate)      count = rotCount;
    else if (ctrl.saturate) count = CNT_W'(DATA_W);
    else                    count = CNT_W'(magnitude);

    // R5/R4/R1/R2/R3: exactly one kind, or none when passing
    p_kind_onehot_r5: assert ($onehot0({ctrl.isLogical, ctrl.isArith, ctrl.isRotate, ctrl.pass}))
      else $error("decoded kind not one-hot");
    p_rot_mod_r9: assert (!ctrl.isRotate || (int'(count) < DATA_W))
      else $error("rotate count not reduced modulo width");
  end

endmodule

// File: rtl/srot_datapath.sv
module srot_datapath
  import srot_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  srotCtrl_t         ctrl,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0]   lowMask, highMask;
  logic [DATA_W-1:0]   shlWord, shrWord, asrWord, aslWord;
  logic [2*DATA_W-1:0] dblWord, rolWide, rorWide;

  always_comb begin
    lowMask  = ~(ONES << count);
    highMask = ~(ONES >> count);
    shlWord  = dataIn << count;
    shrWord  = dataIn >> count;
    aslWord  = shlWord | (lowMask & {DATA_W{dataIn[0]}});
    asrWord  = shrWord | (highMask & {DATA_W{dataIn[DATA_W-1]}});
    dblWord  = {dataIn, dataIn};
    rolWide  = dblWord << count;
    rorWide  = dblWord >> count;

    result = dataIn;
    if (ctrl.isLogical)     result = ctrl.goLeft ? shlWord : shrWord;
    else if (ctrl.isArith)  result = ctrl.goLeft ? aslWord : asrWord;
    else if (ctrl.isRotate) result = ctrl.goLeft ? rolWide[2*DATA_W-1:DATA_W]
                                                 : rorWide[DATA_W-1:0];

    p_pass_r6: assert (!ctrl.pass || (result == dataIn))
      else $error("pass-through altered data");
    p_zero_ident_r7: assert ((count != '0) || (result == dataIn))
      else $error("zero count altered data");
    p_rot_ones_r4: assert (!ctrl.isRotate || ($countones(result) == $countones(dataIn)))
      else $error("rotate lost bits");
    p_sat_logic_r8: assert (!(ctrl.saturate && ctrl.isLogical) || (result == '0))
      else $error("saturated logical shift not zero");
    p_sat_arith_r8: assert (!(ctrl.saturate && ctrl.isArith) || (result == '0) || (result == ONES))
      else $error("saturated arithmetic shift not uniform");
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int AMT_W  = $clog2(DATA_W) + 2
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [2:0]        opSel,
  input  logic [AMT_W-1:0]  amount,
  output logic [DATA_W-1:0] dataOut
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  srotCtrl_t        ctrl;
  logic [CNT_W-1:0] count;

  srot_control #(.DATA_W(DATA_W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_control (
    .opSel (opSel),
    .amount(amount),
    .ctrl  (ctrl),
    .count (count)
  );

  srot_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .ctrl  (ctrl),
    .count (count),
    .dataIn(dataIn),
    .result(dataOut)
  );

endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;

  localparam int W  = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0]  dataIn = '0;
  logic [2:0]    opSel  = '0;
  logic [AW-1:0] amount = '0;
  logic [W-1:0]  dataOut;

  int checks = 0;
  int errors = 0;

  shift_rotate_unit #(.DATA_W(W), .AMT_W(AW)) dut (
    .dataIn(dataIn), .opSel(opSel), .amount(amount), .dataOut(dataOut)
  );

  // {req[3:0], op[2:0], data[3:0], amount[3:0], expected[3:0]}
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1,  3'b000, 4'b1100, 4'd2,    4'b0000},
    {4'd1,  3'b001, 4'b1100, 4'd2,    4'b0011},
    {4'd2,  3'b010, 4'b1110, 4'd1,    4'b1100},
    {4'd2,  3'b010, 4'b0111, 4'd1,    4'b1111},
    {4'd3,  3'b011, 4'b1100, 4'd1,    4'b1110},
    {4'd4,  3'b100, 4'b1100, 4'd2,    4'b0011},
    {4'd4,  3'b101, 4'b1100, 4'd2,    4'b0011},
    {4'd5,  3'b011, 4'b1100, 4'b1111, 4'b1000},
    {4'd5,  3'b100, 4'b1100, 4'b1111, 4'b0110},
    {4'd5,  3'b101, 4'b1100, 4'b1111, 4'b1001},
    {4'd1,  3'b000, 4'b1101, 4'd3,    4'b1000},
    {4'd1,  3'b001, 4'b1101, 4'd3,    4'b0001},
    {4'd6,  3'b110, 4'b1011, 4'd2,    4'b1011},
    {4'd6,  3'b111, 4'b0110, 4'b1101, 4'b0110},
    {4'd7,  3'b000, 4'b1011, 4'd0,    4'b1011},
    {4'd8,  3'b000, 4'b1011, 4'd4,    4'b0000},
    {4'd8,  3'b011, 4'b1011, 4'd4,    4'b1111},
    {4'd8,  3'b010, 4'b0101, 4'd4,    4'b1111},
    {4'd8,  3'b001, 4'b1011, 4'b1000, 4'b0000},
    {4'd9,  3'b100, 4'b1011, 4'd5,    4'b0111},
    {4'd9,  3'b101, 4'b1011, 4'b1100, 4'b1011},
    {4'd8,  3'b011, 4'b0100, 4'd7,    4'b0000}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Bit-by-bit reference
  function automatic logic [W-1:0] refModel(input logic [2:0] op, input logic [W-1:0] d,
                                            input logic [AW-1:0] a);
    logic [W-1:0] o;
    int m, s, kind;
    bit left;
    if (op[2] && op[1]) return d;
    kind = int'(op[2:1]);
    left = (op[0] == 1'b0);
    m = int'($signed(a));
    if (m < 0) begin left = !left; m = -m; end
    for (int i = 0; i < W; i++) begin
      if (kind == 2) begin
        s = left ? (i - (m % W) + W) % W : (i + m) % W;
        o[i] = d[s];
      end else if (left) begin
        s = i - m;
        o[i] = (s >= 0) ? d[s] : ((kind == 1) ? d[0] : 1'b0);
      end else begin
        s = i + m;
        o[i] = (s < W) ? d[s] : ((kind == 1) ? d[W-1] : 1'b0);
      end
    end
    return o;
  endfunction

  task automatic apply(input logic [2:0] op, input logic [W-1:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    opSel = op; dataIn = d; amount = a;
    #2;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (dataOut !== exp) begin
      errors++;
      $display("FAIL %s op=%b data=%b amt=%b actual=%b expected=%b",
               req, opSel, dataIn, amount, dataOut, exp);
    end
  endtask

  initial begin
    // Initial state: all-zero inputs give zero out (R7 identity on 0000)
    #1;
    check("R7", 4'b0000);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][14:12], VEC[v][11:8], VEC[v][7:4]);
      check(reqName(VEC[v][18:15]), VEC[v][3:0]);
    end

    // R6: pass codes ignore every amount
    for (int a = 0; a < 16; a++) begin
      apply(3'b111, 4'b1001, 4'(a));
      check("R6", 4'b1001);
    end

    // R7: zero amount for every code
    for (int op = 0; op < 8; op++) begin
      apply(3'(op), 4'b0110, 4'd0);
      check("R7", 4'b0110);
    end

    // R10: exhaustive sweep, result present in the same cycle
    for (int op = 0; op < 8; op++)
      for (int d = 0; d < 16; d++)
        for (int a = 0; a < 16; a++) begin
          apply(3'(op), 4'(d), 4'(a));
          check("R10", refModel(3'(op), 4'(d), 4'(a)));
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule